// File: doc/BRIEF.md
# Fixed-Latency Memory Channel Model

This block stands in for one memory channel shared by several cache sub-partitions. Each sub-partition offers requests through its own valid/ready port, and a round-robin arbiter takes at most one of them per clock cycle. The arbiter only considers a sub-partition that holds an issue credit. The request it picks is stamped with a ready time, which is a free-running cycle count plus a fixed latency, and placed in an in-order delay line.

When the oldest entry of the delay line is due, it is either retired silently or delivered. A write-back is retired silently. A read or plain write is turned into a reply and offered on the return port of the sub-partition named by its source id. A full return queue at the destination stalls the whole line. Credits are taken on issue and given back when the entry leaves the line. This bounds the work each sub-partition can have in flight.

The model is used in performance and integration benches where a real memory controller is not wanted, but the arbitration and back-pressure behaviour of a shared channel still matters.

Top module: `mcm_channel_model`

## Requirements
- R1: The arbiter scans sub-partitions in rotating order, starting at the index just after the last one granted. After reset, sub-partition 0 is scanned first.
- R2: A sub-partition is eligible only while its `req_valid` is high and it holds at least one credit. `req_ready` is never high without `req_valid`.
- R3: At most one `req_ready` bit is high in any cycle. The scan stops at the first eligible sub-partition.
- R4: Kind 0 (read) counts in the read direction, and kinds 1, 2 and 3 count in the write direction. If the delay line already holds RD_LIMIT read entries (or WR_LIMIT write entries) for the direction of the first eligible request, nothing is granted that cycle, even when a later sub-partition is eligible in the other direction.
- R5: A request granted in cycle c gets ready time c + LATENCY. If nothing blocks it, its reply is offered LATENCY cycles after the grant cycle.
- R6: Entries leave the delay line in grant order, and only once the cycle count is at or past their ready time.
- R7: Kinds 2 and 3 (the two write-back kinds) are retired at the head with no reply on any return port.
- R8: Kinds 0 and 1 are replied to on `ret_valid[d]` with the original tag and kind. The local index d is the source id minus CHAN_ID × NUM_SUB.
- R9: While the head's destination holds `ret_ready` low, the head stays offered unchanged and no entry behind it leaves.
- R10: A grant takes one credit from its sub-partition, and each sub-partition holds at most MAX_CRED credits. The credit is given back to the destination sub-partition when the entry leaves the head, either by an accepted reply or by a write-back retirement.
- R11: After reset all credits are full, the delay line is empty, and no `req_ready` or `ret_valid` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_SUB | Request offered, one bit per sub-partition |
| req_ready | output | NUM_SUB | Request taken this cycle (one-hot or zero) |
| req_kind | input | 2×NUM_SUB | Per sub-partition kind: 0 read, 1 write, 2 and 3 write-back |
| req_src | input | SRC_W×NUM_SUB | Per sub-partition global source id |
| req_tag | input | TAG_W×NUM_SUB | Per sub-partition request tag |
| ret_valid | output | NUM_SUB | Reply offered to the return queue of one sub-partition |
| ret_ready | input | NUM_SUB | Return queue of each sub-partition can take a reply |
| ret_tag | output | TAG_W | Tag of the offered reply |
| ret_kind | output | 2 | Kind of the offered reply |

## Verification
The bound checker watches properties that hold every cycle. These are the one-hot grant and reply vectors, grants only to valid requesters, the per-direction occupancy limits, credit counts never above their maximum, no reply carrying a write-back kind, and a blocked reply held stable. The bench scenarios cover what depends on history. That includes the exact rotation after earlier grants, the cycle at which a reply appears relative to its grant, and the extra delay when credits or direction limits are exhausted. It also covers the in-order drain after a head-of-line stall, and the credit recovered when a write-back retires without a reply.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

   typedef enum logic [1:0] {
      MK_READ    = 2'd0,
      MK_WRITE   = 2'd1,
      MK_WB_NEAR = 2'd2,
      MK_WB_FAR  = 2'd3
   } mcm_kind_e;

   // Every kind except a plain read occupies the write direction.
   function automatic logic kind_is_write(input logic [1:0] k);
      return k != MK_READ;
   endfunction

   // Both write-back kinds retire without a reply.
   function automatic logic kind_is_wb(input logic [1:0] k);
      return k[1];
   endfunction

endpackage

// File: rtl/mcm_credit_bank.sv
module mcm_credit_bank #(
   parameter int NUM      = 4,
   parameter int MAX_CRED = 2,
   localparam int CW      = $clog2(MAX_CRED + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM-1:0]    take,
   input  logic [NUM-1:0]    give,
   output logic [NUM-1:0]    has_cred,
   output logic [NUM*CW-1:0] cred_flat
);

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= CW'(MAX_CRED);
         end else begin
            case ({take[g], give[g]})
               2'b10:   cnt_q <= cnt_q - 1'b1;
               2'b01:   cnt_q <= cnt_q + 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      assign has_cred[g]            = (cnt_q != '0);
      assign cred_flat[g*CW +: CW]  = cnt_q;
   end

endmodule

// File: rtl/mcm_rr_arbiter.sv
module mcm_rr_arbiter #(
   parameter int NUM    = 4,
   localparam int IDX_W = $clog2(NUM)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM-1:0]   elig,
   input  logic [NUM-1:0]   want_wr,
   input  logic             full_rd,
   input  logic             full_wr,
   output logic [NUM-1:0]   gnt,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             gnt_any
);

   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] first;
   logic             found;
   logic             dir_full;

   // Rotating scan: the first eligible index after the last grant wins.
   always_comb begin
      found = 1'b0;
      first = '0;
      for (int p = 0; p < NUM; p++) begin
         if (!found && elig[(int'(last_q) + 1 + p) % NUM]) begin
            found = 1'b1;
            first = IDX_W'((int'(last_q) + 1 + p) % NUM);
         end
      end
   end

   // A full direction for the winner stalls the whole cycle.
   assign dir_full = want_wr[first] ? full_wr : full_rd;
   assign gnt_any  = found && !dir_full;
   assign gnt_idx  = first;
   assign gnt      = gnt_any ? (NUM'(1) << first) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= IDX_W'(NUM - 1);
      else if (gnt_any) last_q <= first;
   end

endmodule

// File: rtl/mcm_delay_fifo.sv
module mcm_delay_fifo #(
   parameter int W      = 16,
   parameter int DEPTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             push_wr,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] rd_cnt,
   output logic [CNT_W-1:0] wr_cnt
);

   logic [W-1:0]     mem [DEPTH];
   logic             dir [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q, wp_nxt, rp_nxt;
   logic             pop_wr;

   // Pointer wrap: free for a power-of-two depth, compared otherwise.
   if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign wp_nxt = wp_q + 1'b1;
      assign rp_nxt = rp_q + 1'b1;
   end else begin : g_odd
      assign wp_nxt = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      assign rp_nxt = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
   end

   assign dout   = mem[rp_q];
   assign pop_wr = dir[rp_q];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp_q] <= din;
         dir[wp_q] <= push_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         rp_q   <= '0;
         count  <= '0;
         rd_cnt <= '0;
         wr_cnt <= '0;
      end else begin
         if (push) wp_q <= wp_nxt;
         if (pop)  rp_q <= rp_nxt;
         count  <= count + CNT_W'(push) - CNT_W'(pop);
         rd_cnt <= rd_cnt + CNT_W'(push && !push_wr) - CNT_W'(pop && !pop_wr);
         wr_cnt <= wr_cnt + CNT_W'(push && push_wr)  - CNT_W'(pop && pop_wr);
      end
   end

endmodule

// File: rtl/mcm_channel_model.sv
module mcm_channel_model #(
   parameter int NUM_SUB  = 4,
   parameter int CHAN_ID  = 1,
   parameter int SRC_W    = 4,
   parameter int TAG_W    = 8,
   parameter int LATENCY  = 6,
   parameter int DEPTH    = 8,
   parameter int MAX_CRED = 2,
   parameter int RD_LIMIT = 4,
   parameter int WR_LIMIT = 3,
   parameter int CYC_W    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SUB-1:0]       req_valid,
   output logic [NUM_SUB-1:0]       req_ready,
   input  logic [2*NUM_SUB-1:0]     req_kind,
   input  logic [SRC_W*NUM_SUB-1:0] req_src,
   input  logic [TAG_W*NUM_SUB-1:0] req_tag,
   output logic [NUM_SUB-1:0]       ret_valid,
   input  logic [NUM_SUB-1:0]       ret_ready,
   output logic [TAG_W-1:0]         ret_tag,
   output logic [1:0]               ret_kind
);
   import mcm_pkg::*;

   localparam int IDX_W = $clog2(NUM_SUB);
   localparam int ENT_W = CYC_W + 2 + SRC_W + TAG_W;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int CR_W  = $clog2(MAX_CRED + 1);

   // Elaboration-time parameter checks
   if (NUM_SUB < 2)                  begin : g_bad_sub  $error("NUM_SUB below 2");           end
   if (LATENCY < 1)                  begin : g_bad_lat  $error("LATENCY below 1");           end
   if (MAX_CRED < 1)                 begin : g_bad_cred $error("MAX_CRED below 1");          end
   if (RD_LIMIT < 1 || RD_LIMIT > DEPTH) begin : g_bad_rl $error("RD_LIMIT out of range");   end
   if (WR_LIMIT < 1 || WR_LIMIT > DEPTH) begin : g_bad_wl $error("WR_LIMIT out of range");   end
   if ((CHAN_ID + 1) * NUM_SUB > (1 << SRC_W)) begin : g_bad_src $error("SRC_W too narrow"); end

   logic [CYC_W-1:0]          cyc_q;
   logic [NUM_SUB-1:0]        has_cred, elig, want_wr, gnt, give;
   logic [NUM_SUB*CR_W-1:0]   cred_flat;
   logic [IDX_W-1:0]          gnt_idx;
   logic                      gnt_any;
   logic [CNT_W-1:0]          count, rd_cnt, wr_cnt;
   logic                      full_rd, full_wr;
   logic [ENT_W-1:0]          push_ent, head_ent;
   logic [1:0]                push_kind;
   logic [CYC_W-1:0]          head_due;
   logic [1:0]                head_kind;
   logic [SRC_W-1:0]          head_src;
   logic [TAG_W-1:0]          head_tag;
   logic                      head_ok, head_wb, pop;
   logic [IDX_W-1:0]          dest;

   // Free-running time base for ready stamps
   always_ff @(posedge clk) begin
      if (!rst_n) cyc_q <= '0;
      else        cyc_q <= cyc_q + 1'b1;
   end

   // Issue side
   for (genvar g = 0; g < NUM_SUB; g++) begin : g_req
      assign want_wr[g] = kind_is_write(req_kind[2*g +: 2]);
   end
   assign elig = req_valid & has_cred;

   assign full_rd = (rd_cnt >= CNT_W'(RD_LIMIT)) || (count == CNT_W'(DEPTH));
   assign full_wr = (wr_cnt >= CNT_W'(WR_LIMIT)) || (count == CNT_W'(DEPTH));

   mcm_rr_arbiter #(.NUM(NUM_SUB)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .want_wr (want_wr),
      .full_rd (full_rd),
      .full_wr (full_wr),
      .gnt     (gnt),
      .gnt_idx (gnt_idx),
      .gnt_any (gnt_any)
   );
   assign req_ready = gnt;

   assign push_kind = req_kind[int'(gnt_idx)*2 +: 2];
   assign push_ent  = {cyc_q + CYC_W'(LATENCY),
                       push_kind,
                       req_src[int'(gnt_idx)*SRC_W +: SRC_W],
                       req_tag[int'(gnt_idx)*TAG_W +: TAG_W]};

   mcm_delay_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (gnt_any),
      .push_wr (kind_is_write(push_kind)),
      .din     (push_ent),
      .pop     (pop),
      .dout    (head_ent),
      .count   (count),
      .rd_cnt  (rd_cnt),
      .wr_cnt  (wr_cnt)
   );

   // Return side
   assign {head_due, head_kind, head_src, head_tag} = head_ent;
   assign head_ok = (count != '0) && (cyc_q >= head_due);
   assign head_wb = kind_is_wb(head_kind);
   assign dest    = IDX_W'(head_src - SRC_W'(CHAN_ID * NUM_SUB));
   assign pop     = head_ok && (head_wb || ret_ready[dest]);

   always_comb begin
      ret_valid = '0;
      give      = '0;
      for (int i = 0; i < NUM_SUB; i++) begin
         ret_valid[i] = head_ok && !head_wb && (dest == IDX_W'(i));
         give[i]      = pop && (dest == IDX_W'(i));
      end
   end
   assign ret_tag  = head_tag;
   assign ret_kind = head_kind;

   mcm_credit_bank #(.NUM(NUM_SUB), .MAX_CRED(MAX_CRED)) u_cred (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (gnt),
      .give      (give),
      .has_cred  (has_cred),
      .cred_flat (cred_flat)
   );

endmodule

// File: rtl/mcm_channel_checker.sv
module mcm_channel_checker #(
   parameter int NUM_SUB  = 4,
   parameter int TAG_W    = 8,
   parameter int CNT_W    = 4,
   parameter int CR_W     = 2,
   parameter int MAX_CRED = 2,
   parameter int RD_LIMIT = 4,
   parameter int WR_LIMIT = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_SUB-1:0]       req_valid,
   input logic [NUM_SUB-1:0]       req_ready,
   input logic [NUM_SUB-1:0]       ret_valid,
   input logic [NUM_SUB-1:0]       ret_ready,
   input logic [TAG_W-1:0]         ret_tag,
   input logic [1:0]               ret_kind,
   input logic [CNT_W-1:0]         rd_cnt,
   input logic [CNT_W-1:0]         wr_cnt,
   input logic [NUM_SUB*CR_W-1:0]  cred_flat
);

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));                                                  // R3

   AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0);                                       // R2

   AST_ONE_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ret_valid));                                                  // R8

   AST_NO_WB_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid != '0) |-> !ret_kind[1]);                                   // R7

   AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_valid & ~ret_ready) != '0) |=>
         (ret_valid == $past(ret_valid)) && $stable(ret_tag) && $stable(ret_kind)); // R9

   AST_RD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= CNT_W'(RD_LIMIT));                                           // R4

   AST_WR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= CNT_W'(WR_LIMIT));                                           // R4

   for (genvar g = 0; g < NUM_SUB; g++) begin : g_cr
      AST_CRED_MAX: assert property (@(posedge clk) disable iff (!rst_n)
         cred_flat[g*CR_W +: CR_W] <= CR_W'(MAX_CRED));                      // R10
   end

endmodule

bind mcm_channel_model mcm_channel_checker #(
   .NUM_SUB  (NUM_SUB),
   .TAG_W    (TAG_W),
   .CNT_W    (CNT_W),
   .CR_W     (CR_W),
   .MAX_CRED (MAX_CRED),
   .RD_LIMIT (RD_LIMIT),
   .WR_LIMIT (WR_LIMIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .ret_valid (ret_valid),
   .ret_ready (ret_ready),
   .ret_tag   (ret_tag),
   .ret_kind  (ret_kind),
   .rd_cnt    (rd_cnt),
   .wr_cnt    (wr_cnt),
   .cred_flat (cred_flat)
);

// File: tb/mcm_channel_model_bench.sv
module mcm_channel_model_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NS  = 4;
   localparam int CH  = 1;
   localparam int SW  = 4;
   localparam int TW  = 8;
   localparam int LAT = 6;
   localparam int DEP = 8;
   localparam int MC  = 2;
   localparam int RL  = 4;
   localparam int WL  = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NS-1:0]    req_valid, req_ready, ret_valid, ret_ready;
   logic [2*NS-1:0]  req_kind;
   logic [SW*NS-1:0] req_src;
   logic [TW*NS-1:0] req_tag;
   logic [TW-1:0]    ret_tag;
   logic [1:0]       ret_kind;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcm_channel_model #(
      .NUM_SUB(NS), .CHAN_ID(CH), .SRC_W(SW), .TAG_W(TW), .LATENCY(LAT),
      .DEPTH(DEP), .MAX_CRED(MC), .RD_LIMIT(RL), .WR_LIMIT(WL), .CYC_W(32)
   ) u_mcm_channel_model (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_src(req_src), .req_tag(req_tag),
      .ret_valid(ret_valid), .ret_ready(ret_ready),
      .ret_tag(ret_tag), .ret_kind(ret_kind)
   );

   int  tbc = 0;
   int  checks = 0;
   int  fails = 0;
   bit  done = 0;

   logic [1:0] bq_kind [NS][8];
   logic [7:0] bq_tag  [NS][8];
   int         bq_hd [NS];
   int         bq_tl [NS];
   logic [NS-1:0] took;

   int         gnt_cyc [256];
   int         ret_cyc [256];
   int         ret_dst [256];
   logic [1:0] ret_knd [256];
   bit         ret_any [256];

   always @(posedge clk) tbc <= tbc + 1;

   // Monitor: samples at the falling edge
   always @(negedge clk) begin
      for (int i = 0; i < NS; i++) begin
         if (req_valid[i] && req_ready[i]) begin
            gnt_cyc[bq_tag[i][bq_hd[i] % 8]] = tbc;
            took[i] = 1'b1;
         end
         if (ret_valid[i]) ret_any[ret_tag] = 1'b1;
         if (ret_valid[i] && ret_ready[i]) begin
            ret_cyc[ret_tag] = tbc;
            ret_dst[ret_tag] = i;
            ret_knd[ret_tag] = ret_kind;
         end
      end
   end

   task automatic present();
      for (int i = 0; i < NS; i++) begin
         req_valid[i]          = (bq_hd[i] != bq_tl[i]);
         req_kind[2*i +: 2]    = bq_kind[i][bq_hd[i] % 8];
         req_tag[TW*i +: TW]   = bq_tag[i][bq_hd[i] % 8];
         req_src[SW*i +: SW]   = SW'(CH * NS + i);
      end
   endtask

   // Driver: advances each queue after a taken request
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < NS; i++) begin
         if (took[i]) begin
            bq_hd[i] = bq_hd[i] + 1;
            took[i]  = 1'b0;
         end
      end
      present();
   end

   task automatic push(input int sub, input logic [1:0] kind, input logic [7:0] tag);
      bq_kind[sub][bq_tl[sub] % 8] = kind;
      bq_tag[sub][bq_tl[sub] % 8]  = tag;
      bq_tl[sub] = bq_tl[sub] + 1;
      present();
   endtask

   task automatic check(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int i = 0; i < NS; i++) begin
         bq_hd[i] = 0;
         bq_tl[i] = 0;
      end
      took      = '0;
      ret_ready = '1;
      present();
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   // R11: reset state
   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      check(req_ready == '0, "R11 req_ready after reset", int'(req_ready), 0);
      check(ret_valid == '0, "R11 ret_valid after reset", int'(ret_valid), 0);
      wait_cyc(1);
   endtask

   // R1 R3 R5 R8: rotation and reply timing
   task automatic t_rotation();
      do_reset();
      for (int i = 0; i < NS; i++) push(i, 2'd0, 8'(10 + i));
      wait_cyc(LAT + 8);
      for (int i = 1; i < NS; i++)
         check(gnt_cyc[10 + i] == gnt_cyc[10] + i, "R1 grant order from sub 0",
               gnt_cyc[10 + i] - gnt_cyc[10], i);
      for (int i = 0; i < NS; i++) begin
         check(ret_cyc[10 + i] == gnt_cyc[10 + i] + LAT, "R5 reply latency",
               ret_cyc[10 + i] - gnt_cyc[10 + i], LAT);
         check(ret_dst[10 + i] == i, "R8 reply destination", ret_dst[10 + i], i);
      end
      // last granted was 3: sub 0 before sub 2
      push(2, 2'd0, 8'd14);
      push(0, 2'd0, 8'd15);
      wait_cyc(LAT + 4);
      check(gnt_cyc[14] == gnt_cyc[15] + 1, "R1 wrap after last grant 3",
            gnt_cyc[14] - gnt_cyc[15], 1);
      // last granted was 2: sub 3 before sub 1
      push(1, 2'd0, 8'd16);
      push(3, 2'd0, 8'd17);
      wait_cyc(LAT + 4);
      check(gnt_cyc[16] == gnt_cyc[17] + 1, "R1 rotation after last grant 2",
            gnt_cyc[16] - gnt_cyc[17], 1);
   endtask

   // R2 R10: credit exhaustion and return
   task automatic t_credit();
      do_reset();
      push(0, 2'd0, 8'd20);
      push(0, 2'd0, 8'd21);
      push(0, 2'd0, 8'd22);
      push(1, 2'd0, 8'd23);
      wait_cyc(2 * LAT + 6);
      check(gnt_cyc[23] == gnt_cyc[20] + 1, "R1 sub 1 after sub 0",
            gnt_cyc[23] - gnt_cyc[20], 1);
      check(gnt_cyc[21] == gnt_cyc[20] + 2, "R2 second credit used",
            gnt_cyc[21] - gnt_cyc[20], 2);
      check(gnt_cyc[22] == gnt_cyc[20] + LAT + 1, "R10 third waits for credit",
            gnt_cyc[22] - gnt_cyc[20], LAT + 1);
      check(ret_cyc[22] == gnt_cyc[22] + LAT, "R6 late entry reply",
            ret_cyc[22] - gnt_cyc[22], LAT);
   endtask

   // R7 R10: write-backs retire silently and free credit
   task automatic t_writeback();
      do_reset();
      push(2, 2'd2, 8'd40);
      push(2, 2'd3, 8'd41);
      push(2, 2'd0, 8'd42);
      wait_cyc(2 * LAT + 6);
      check(!ret_any[40], "R7 write-back kind 2 no reply", int'(ret_any[40]), 0);
      check(!ret_any[41], "R7 write-back kind 3 no reply", int'(ret_any[41]), 0);
      check(gnt_cyc[42] == gnt_cyc[40] + LAT + 1, "R10 credit back on retire",
            gnt_cyc[42] - gnt_cyc[40], LAT + 1);
      check(ret_cyc[42] == gnt_cyc[42] + LAT && ret_dst[42] == 2, "R8 read after write-backs",
            ret_cyc[42] - gnt_cyc[42], LAT);
   endtask

   // R9: head-of-line blocking
   task automatic t_blocked();
      do_reset();
      ret_ready[1] = 1'b0;
      push(1, 2'd0, 8'd50);
      wait_cyc(1);
      push(3, 2'd1, 8'd51);
      wait_cyc(LAT + 8);
      check(ret_valid == 4'b0010, "R9 blocked head still offered", int'(ret_valid), 2);
      check(!ret_any[51], "R9 entry behind blocked head held", int'(ret_any[51]), 0);
      ret_ready[1] = 1'b1;
      wait_cyc(3);
      check(ret_cyc[51] == ret_cyc[50] + 1, "R6 in-order drain after stall",
            ret_cyc[51] - ret_cyc[50], 1);
      check(ret_knd[51] == 2'd1 && ret_dst[51] == 3, "R8 plain write reply on sub 3",
            int'(ret_knd[51]), 1);
   endtask

   // R4: direction limit stalls the whole scan
   task automatic t_direction();
      do_reset();
      push(0, 2'd1, 8'd60);
      push(0, 2'd0, 8'd64);
      push(1, 2'd1, 8'd61);
      push(2, 2'd1, 8'd62);
      push(3, 2'd1, 8'd63);
      wait_cyc(2 * LAT + 6);
      check(gnt_cyc[62] == gnt_cyc[60] + 2, "R4 writes up to limit",
            gnt_cyc[62] - gnt_cyc[60], 2);
      check(gnt_cyc[63] == gnt_cyc[60] + LAT + 1, "R4 write waits for slot",
            gnt_cyc[63] - gnt_cyc[60], LAT + 1);
      check(gnt_cyc[64] == gnt_cyc[60] + LAT + 2, "R4 read not granted past stalled write",
            gnt_cyc[64] - gnt_cyc[60], LAT + 2);
   endtask

   initial begin
      for (int t = 0; t < 256; t++) begin
         gnt_cyc[t] = -1;
         ret_cyc[t] = -1;
         ret_dst[t] = -1;
         ret_knd[t] = '0;
         ret_any[t] = 1'b0;
      end
      took = '0;
      ret_ready = '1;
      for (int i = 0; i < NS; i++) begin
         bq_hd[i] = 0;
         bq_tl[i] = 0;
      end
      present();
      t_reset_state();
      t_rotation();
      t_credit();
      t_writeback();
      t_blocked();
      t_direction();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: got %0d expected %0d", 5000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule